// File: doc/BRIEF.md
# Receive Byte Buffer with Idle Timeout

This block is the receive-side buffer of a serial controller that can run with or without a FIFO. A deserializer hands it finished bytes, and it can also report a line break. Software drains the buffer through a data-register read strobe. The block keeps a 16-entry first-in first-out store of received bytes. It raises a threshold flag once the fill level reaches a software-selected trigger. It also watches for the line going quiet while bytes are still waiting.

The block owns three line-status bits: data-ready, overrun and break. The interrupt encoder and the register file decode these bits and the two flags. A control write chooses FIFO or single-byte mode and selects the trigger level. The same write can also flush the store. A separate status-read strobe clears the sticky error bits. A one-character-time pulse from the baud logic sets the pace of the idle timer.

Top module: `rx_char_buffer`

## Requirements
- R1: After reset the fill level is 0, data-ready, overrun, break, threshold and idle-pending are all low, FIFO mode is off and rd_data reads 0x00.
- R2: In FIFO mode, bytes come out in arrival order. rd_data shows the oldest byte in the same cycle as rd_stb, and `level` counts the stored bytes. data-ready is high exactly when `level` is nonzero.
- R3: In FIFO mode, a byte that arrives with 16 bytes stored (and no read in the same cycle) is discarded and sets the overrun bit. The stored bytes and their order are kept.
- R4: A break pulse stores a 0x00 byte and sets both break and data-ready. A read that empties the store clears break.
- R5: cfg_data bits 7:6 select the trigger level: 00 selects 1 byte, 01 selects 4, 10 selects 8 and 11 selects 14. In FIFO mode trig_hit is high when `level` is at or above the selected level. In single-byte mode trig_hit follows data-ready.
- R6: In FIFO mode, the idle timer restarts on every arriving byte and on every read that leaves bytes behind. The fourth char_tick after a restart sets idle_pend if bytes remain.
- R7: Any rd_stb clears idle_pend. A read that empties the store stops the timer, so later ticks leave idle_pend low.
- R8: A read of an empty store returns 0x00 and leaves `level` at 0.
- R9: A control write with cfg_data bit 1 set, or one whose bit 0 differs from the current mode, empties the store. It also clears data-ready, break and idle-pending and stops the timer. A flush has priority over any byte arriving in the same cycle.
- R10: A status read (stat_rd) clears overrun and break but not data-ready. An event that sets one of those bits in the same cycle takes priority over the clear.
- R11: In single-byte mode (cfg_data bit 0 = 0) one byte is held. A byte that arrives while one is held replaces it and sets overrun.
- R12: A byte arrival and a read in the same cycle with the store non-empty are both performed, and `level` is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | A received byte is presented on rx_byte |
| rx_byte | input | 8 | Received byte |
| brk_evt | input | 1 | Line break detected; stores 0x00 (wins over rx_valid) |
| rd_stb | input | 1 | Data-register read: pops the oldest byte |
| cfg_wr | input | 1 | Control write strobe |
| cfg_data | input | 8 | Control value: bit 0 FIFO mode, bit 1 flush, bits 7:6 trigger select |
| stat_rd | input | 1 | Line-status read: clears overrun and break |
| char_tick | input | 1 | One pulse per character time |
| rd_data | output | 8 | Oldest stored byte, 0x00 when empty |
| level | output | 5 | Number of stored bytes |
| data_rdy | output | 1 | At least one byte stored |
| ovr_err | output | 1 | Sticky overrun bit |
| brk_flag | output | 1 | Sticky break bit |
| trig_hit | output | 1 | Fill level at or above the trigger |
| idle_pend | output | 1 | Character timeout pending |

## Verification
rd_data is combinational from the head of the store, so it is due in the same cycle as rd_stb. The bench's monitor samples it at the falling edge inside that cycle and compares it with the front of a scoreboard queue. `level`, data-ready, overrun, break, trig_hit and idle_pend are all registered and change at the first rising edge that samples the stimulus. The bench therefore drives each input one nanosecond after a rising edge and reads these flags one nanosecond after the following rising edge. For the idle timer, each char_tick pulse counts at the edge that samples it, so idle_pend is checked low after the third pulse and high after the fourth.

// File: rtl/rx_buf_pkg.sv
`timescale 1ns/1ps
package rx_buf_pkg;

    typedef enum logic [1:0] {
        TRIG_ONE  = 2'b00,
        TRIG_FOUR = 2'b01,
        TRIG_EIGHT = 2'b10,
        TRIG_FOURTEEN = 2'b11
    } trig_sel_e;

    typedef struct packed {
        logic      fifo_en;
        trig_sel_e trig;
        logic      ovr;
        logic      brk;
    } ctl_s;

    function automatic int trig_bytes(trig_sel_e sel);
        case (sel)
            TRIG_ONE:   return 1;
            TRIG_FOUR:  return 4;
            TRIG_EIGHT: return 8;
            default:    return 14;
        endcase
    endfunction

endpackage

// File: rtl/rx_byte_store.sv
`timescale 1ns/1ps
module rx_byte_store #(
    parameter int DEPTH = 16,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    input  logic          flush,
    input  logic          fifo_mode,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] head,
    output logic [CW-1:0] count,
    output logic          overrun
);

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
    } ptr_s;

    ptr_s st_d, st_q;
    logic [DW-1:0] mem [DEPTH];
    logic          wr_en;
    logic [AW-1:0] wr_addr;
    logic          full, do_pop, accept;

    function automatic logic [AW-1:0] nxt(logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d    = st_q;
        wr_en   = 1'b0;
        wr_addr = st_q.wp;
        full    = fifo_mode ? (st_q.cnt == CW'(DEPTH)) : (st_q.cnt != '0);
        do_pop  = pop && (st_q.cnt != '0);
        accept  = 1'b0;
        overrun = 1'b0;
        if (flush) begin
            st_d = '0;
        end else begin
            if (do_pop) st_d.rp = nxt(st_q.rp);
            if (push) begin
                if (!full || do_pop) begin
                    accept  = 1'b1;
                    wr_en   = 1'b1;
                    st_d.wp = nxt(st_q.wp);
                end else begin
                    overrun = 1'b1;
                    if (!fifo_mode) begin
                        wr_en   = 1'b1;
                        wr_addr = st_q.rp;
                    end
                end
            end
            st_d.cnt = st_q.cnt + CW'(accept) - CW'(do_pop);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wdata;
    end

    assign count = st_q.cnt;
    assign head  = (st_q.cnt != '0) ? mem[st_q.rp] : '0;

    a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));

    a_r3_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_mode && push && !pop && !flush && count == CW'(DEPTH)
        |=> count == CW'(DEPTH));

    a_r12_push_pop_level: assert property (@(posedge clk) disable iff (!rst_n)
        push && pop && !flush && count != '0 |=> count == $past(count));

endmodule

// File: rtl/rx_idle_timer.sv
`timescale 1ns/1ps
module rx_idle_timer #(
    parameter int TICKS = 4,
    localparam int TW   = $clog2(TICKS + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic halt,
    input  logic tick,
    input  logic clr,
    input  logic has_data,
    output logic pend
);

    typedef struct packed {
        logic [TW-1:0] cnt;
        logic          run;
        logic          pend;
    } tmr_s;

    tmr_s t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (clr) t_d.pend = 1'b0;
        if (halt) begin
            t_d.run = 1'b0;
            t_d.cnt = '0;
        end else if (restart) begin
            t_d.run = 1'b1;
            t_d.cnt = '0;
        end else if (t_q.run && tick) begin
            if (t_q.cnt == TW'(TICKS - 1)) begin
                t_d.cnt = TW'(TICKS);
                t_d.run = 1'b0;
                if (has_data) t_d.pend = 1'b1;
            end else begin
                t_d.cnt = t_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign pend = t_q.pend;

    a_r6_pend_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend) |-> $past(tick));

    a_r7_clr_drops_pend: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !pend);

endmodule

// File: rtl/rx_char_buffer.sv
`timescale 1ns/1ps
module rx_char_buffer
    import rx_buf_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int TICKS = 4,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_valid,
    input  logic [7:0]    rx_byte,
    input  logic          brk_evt,
    input  logic          rd_stb,
    input  logic          cfg_wr,
    input  logic [7:0]    cfg_data,
    input  logic          stat_rd,
    input  logic          char_tick,
    output logic [7:0]    rd_data,
    output logic [CW-1:0] level,
    output logic          data_rdy,
    output logic          ovr_err,
    output logic          brk_flag,
    output logic          trig_hit,
    output logic          idle_pend
);

    ctl_s c_d, c_q;
    logic       flush, push, empties, overrun;
    logic       t_restart, t_halt;
    logic [7:0] wdata;

    always_comb begin
        flush   = cfg_wr && (cfg_data[1] || (cfg_data[0] != c_q.fifo_en));
        push    = rx_valid || brk_evt;
        wdata   = brk_evt ? 8'h00 : rx_byte;
        empties = rd_stb && (level <= CW'(1)) && !push;

        t_restart = c_q.fifo_en && push;
        if (rd_stb && (level > CW'(1))) t_restart = c_q.fifo_en;
        t_halt    = flush || empties || !c_q.fifo_en;

        c_d = c_q;
        if (cfg_wr) begin
            c_d.fifo_en = cfg_data[0];
            c_d.trig    = trig_sel_e'(cfg_data[7:6]);
        end
        if (stat_rd) begin
            c_d.ovr = 1'b0;
            c_d.brk = 1'b0;
        end
        if (empties) c_d.brk = 1'b0;
        if (overrun) c_d.ovr = 1'b1;
        if (brk_evt) c_d.brk = 1'b1;
        if (flush)   c_d.brk = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '{fifo_en: 1'b0, trig: TRIG_ONE, ovr: 1'b0, brk: 1'b0};
        else        c_q <= c_d;
    end

    rx_byte_store #(.DEPTH(DEPTH), .DW(8)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .pop       (rd_stb),
        .flush     (flush),
        .fifo_mode (c_q.fifo_en),
        .wdata     (wdata),
        .head      (rd_data),
        .count     (level),
        .overrun   (overrun)
    );

    rx_idle_timer #(.TICKS(TICKS)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (t_restart),
        .halt     (t_halt),
        .tick     (char_tick),
        .clr      (rd_stb || flush),
        .has_data (level != '0),
        .pend     (idle_pend)
    );

    assign data_rdy = (level != '0);
    assign ovr_err  = c_q.ovr;
    assign brk_flag = c_q.brk;
    assign trig_hit = c_q.fifo_en ? (level >= CW'(trig_bytes(c_q.trig))) : data_rdy;

    a_r4_break_sets: assert property (@(posedge clk) disable iff (!rst_n)
        brk_evt && !flush |=> brk_flag && data_rdy);

    a_r9_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr && cfg_data[1] |=> level == '0 && !idle_pend && !brk_flag);

    a_r10_status_clear: assert property (@(posedge clk) disable iff (!rst_n)
        stat_rd && !push |=> !ovr_err);

    a_r6_pend_has_data: assert property (@(posedge clk) disable iff (!rst_n)
        idle_pend |-> data_rdy);

endmodule

// File: tb/rx_char_buffer_test.sv
`timescale 1ns/1ps
module rx_char_buffer_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_valid = 0, brk_evt = 0, rd_stb = 0, cfg_wr = 0, stat_rd = 0, char_tick = 0;
    logic [7:0] rx_byte = 0, cfg_data = 0;
    logic [7:0] rd_data;
    logic [4:0] level;
    logic       data_rdy, ovr_err, brk_flag, trig_hit, idle_pend;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    bit fifo_on = 0;
    logic [7:0] sb_q[$];

    always #2.5 clk = ~clk;

    rx_char_buffer uut (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .brk_evt(brk_evt), .rd_stb(rd_stb), .cfg_wr(cfg_wr), .cfg_data(cfg_data),
        .stat_rd(stat_rd), .char_tick(char_tick), .rd_data(rd_data), .level(level),
        .data_rdy(data_rdy), .ovr_err(ovr_err), .brk_flag(brk_flag),
        .trig_hit(trig_hit), .idle_pend(idle_pend)
    );

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor: pops the scoreboard whenever a read is in progress
    always @(negedge clk) begin
        if (rst_n && rd_stb) begin
            logic [7:0] e;
            e = (sb_q.size() != 0) ? sb_q.pop_front() : 8'h00;
            chk("R2/R8 rd_data", rd_data, e);
        end
    end

    task automatic edge1();
        @(posedge clk);
        #1;
    endtask

    task automatic model_push(logic [7:0] b);
        if (fifo_on) begin
            if (sb_q.size() < 16) sb_q.push_back(b);
        end else begin
            if (sb_q.size() == 0) sb_q.push_back(b);
            else sb_q[0] = b;
        end
    endtask

    task automatic push(logic [7:0] b);
        rx_valid = 1; rx_byte = b;
        edge1();
        rx_valid = 0;
        model_push(b);
    endtask

    task automatic rd();
        rd_stb = 1;
        edge1();
        rd_stb = 0;
    endtask

    task automatic cfg(logic [7:0] v);
        cfg_wr = 1; cfg_data = v;
        edge1();
        cfg_wr = 0;
        if (v[1] || (v[0] != fifo_on)) sb_q.delete();
        fifo_on = v[0];
    endtask

    task automatic tick();
        char_tick = 1;
        edge1();
        char_tick = 0;
    endtask

    task automatic lsr();
        stat_rd = 1;
        edge1();
        stat_rd = 0;
    endtask

    initial begin
        #1000000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #12 rst_n = 1;
        edge1();
        // R1 reset state
        chk("R1 level", level, 0);
        chk("R1 flags", {data_rdy, ovr_err, brk_flag, trig_hit, idle_pend}, 0);
        chk("R1 rd_data", rd_data, 0);

        // R2/R5 FIFO order, trigger 1
        cfg(8'h01);
        push(8'h11); push(8'h22); push(8'h33);
        chk("R2 level", level, 3);
        chk("R5 trig level1", trig_hit, 1);
        chk("R2 data_rdy", data_rdy, 1);
        rd(); rd(); rd();
        chk("R2 drained", {level, data_rdy}, 0);

        // R8 empty read
        rd();
        chk("R8 level stays 0", level, 0);

        // R5 trigger 8 then 14; R3 overrun
        cfg(8'h81);
        for (int i = 0; i < 7; i++) push(8'h40 + 8'(i));
        chk("R5 below 8", trig_hit, 0);
        push(8'h47);
        chk("R5 at 8", trig_hit, 1);
        cfg(8'hC1);
        chk("R5 below 14", trig_hit, 0);
        chk("R5 no flush on same mode", level, 8);
        for (int i = 8; i < 16; i++) push(8'h40 + 8'(i));
        chk("R5 at 14+", trig_hit, 1);
        chk("R3 full", level, 16);
        chk("R3 no ovr yet", ovr_err, 0);
        push(8'hEE);
        chk("R3 level kept", level, 16);
        chk("R3 overrun set", ovr_err, 1);
        for (int i = 0; i < 16; i++) rd();
        chk("R3 drained", level, 0);
        chk("R10 ovr sticky before lsr", ovr_err, 1);
        lsr();
        chk("R10 ovr cleared", ovr_err, 0);

        // R4 break
        cfg(8'h01);
        brk_evt = 1; edge1(); brk_evt = 0; model_push(8'h00);
        chk("R4 break flag", brk_flag, 1);
        chk("R4 data_rdy", data_rdy, 1);
        rd();
        chk("R4 brk cleared by emptying read", brk_flag, 0);
        brk_evt = 1; edge1(); brk_evt = 0; model_push(8'h00);
        lsr();
        chk("R10 brk cleared by lsr", brk_flag, 0);
        chk("R10 dr kept", data_rdy, 1);
        rd();

        // R6/R7 timeout
        push(8'h51); push(8'h52);
        tick(); tick(); tick();
        chk("R6 not yet", idle_pend, 0);
        tick();
        chk("R6 fired", idle_pend, 1);
        rd();
        chk("R7 read clears", idle_pend, 0);
        tick(); tick(); tick(); tick();
        chk("R6 restarted by read", idle_pend, 1);
        rd();
        chk("R7 empty", {level, idle_pend}, 0);
        for (int i = 0; i < 5; i++) tick();
        chk("R7 timer stopped", idle_pend, 0);

        // R9 flush
        push(8'h61); push(8'h62);
        tick(); tick(); tick(); tick();
        chk("R9 pend before flush", idle_pend, 1);
        cfg(8'h03);
        chk("R9 bit1 flush", {level, idle_pend, data_rdy}, 0);
        push(8'h63);
        cfg(8'h00);
        chk("R9 toggle flush", level, 0);

        // R11 single-byte mode
        push(8'hA1);
        chk("R11 held", {data_rdy, trig_hit, ovr_err}, 3'b110);
        push(8'hB2);
        chk("R11 level one", level, 1);
        chk("R11 overrun", ovr_err, 1);
        for (int i = 0; i < 5; i++) tick();
        chk("R11 no timer", idle_pend, 0);
        rd();
        chk("R11 emptied", data_rdy, 0);
        lsr();

        // R12 simultaneous push and read
        cfg(8'h01);
        push(8'h71); push(8'h72);
        rx_valid = 1; rx_byte = 8'h73; rd_stb = 1;
        edge1();
        rx_valid = 0; rd_stb = 0;
        model_push(8'h73);
        chk("R12 level unchanged", level, 2);
        rd(); rd();
        chk("R12 drained", level, 0);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule